// File: doc/BRIEF.md
# Half-Bridge PWM Generator with Duty Floor

This block turns an 8-bit speed command into the gate enables of one half-bridge. A free-running carrier counter is compared with a duty code. The duty code comes from two sources. The first is the speed command, scaled linearly between a lower and an upper threshold. The second is a separate minimum-duty code, which sets a floor. The duty used is the larger of the two, and it is captured only when the carrier wraps, so a period never changes its duty partway through. While the high side is off, the low side conducts for synchronous rectification. A programmable dead time keeps the two sides from ever conducting together.

A peak-current-limit input cuts the high-side pulse. The cut lasts until the end of the current carrier period. A sensor-bias enable output is dropped in two cases: when the command falls below a low cut-off and no floor is configured, or when the block is stopped. A low level on `run_en` selects stop mode. In stop mode both gate enables are forced off and the carrier is held ready to start a fresh period.

All pins are plain level signals sampled on the clock. The block has no streaming data path, so it has no handshake.

Top module: `pwm_floor_gen`

## Requirements
- R1: While reset is asserted and on the first clock after it, `hs_en`, `ls_en` and `bias_en` are all low.
- R2: The command duty D_cmd, in carrier steps out of 256, is computed as follows. It is 0 when `speed_cmd` <= LO_THR (32). It is 256 when `speed_cmd` >= HI_THR (160). Between the two it is (speed_cmd-32)*256/128, rounded down. In each period the high side is requested for carrier counts 0 to D-1.
- R3: The duty D applied is max(D_cmd, `min_duty`), so the high-side request never lasts for fewer than `min_duty` carrier steps.
- R4: When `min_duty` is 0 and D_cmd is 0, the high side is never enabled and the low side stays on for the whole period.
- R5: D is captured only in the cycle in which the carrier count is 255 and the block is running. A command change during a period first affects the next period.
- R6: While running, whenever the high side is not requested, the low side is requested (synchronous rectification).
- R7: A cycle with `ilim_trip` high removes the high-side request from that cycle until the end of the carrier period. `hs_en` is low on the following clock. The blanking clears when the carrier wraps.
- R8: Gate outputs are registered. After any change of the requested side, both enables are low for `dead_cfg`+1 clocks before the new side turns on. In steady state, a period with 0<D<256 has D-`dead_cfg`-1 clocks of `hs_en` and 256-D-`dead_cfg`-1 clocks of `ls_en`.
- R9: `hs_en` and `ls_en` are never high in the same cycle.
- R10: One clock after its inputs, `bias_en` equals `run_en` AND NOT (`min_duty`==0 AND `speed_cmd` < CUT_THR (16)).
- R11: When `run_en` is low, all three outputs are low on the next clock. The carrier is held at 255 with D at 0. The first running cycle is therefore a wrap that captures D, and both gate enables stay low for `dead_cfg`+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | 1 = run, 0 = stop mode |
| speed_cmd | input | 8 | Speed command code |
| min_duty | input | 8 | Duty floor in carrier steps; 0 = no floor |
| ilim_trip | input | 1 | Peak-current-limit indication |
| dead_cfg | input | 4 | Dead time in clocks (gap is dead_cfg+1) |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| bias_en | output | 1 | Sensor-bias enable |

## Verification
All outputs are registered, so each output responds to an input on the next clock. The exception is a change of the requested side, whose new gate enable arrives `dead_cfg`+2 clocks later. A command change takes effect only in the period after the next wrap. Steady-state checks therefore wait two full periods before counting enable cycles. Directed checks after a current trip or a mid-period command change are placed at carrier counts derived from the run start: the first running clock is count 255, and after the j-th running clock (j>=2) the outputs reflect count j-2. A cycle-accurate reference model is compared on every falling edge.

// File: rtl/pwm_floor_pkg.sv
package pwm_floor_pkg;
  typedef enum logic {
    SIDE_LOW  = 1'b0,
    SIDE_HIGH = 1'b1
  } side_e;
endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier #(
  parameter int CW     = 8,
  parameter int LO_THR = 32,
  parameter int HI_THR = 160
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] speed_cmd,
  input  logic [CW-1:0] min_duty,
  input  logic          ilim_trip,
  output logic          hs_req
);
  localparam int SPAN     = HI_THR - LO_THR;
  localparam int SPAN_LOG = $clog2(SPAN);
  localparam int WW       = 2 * CW + 1;
  localparam logic [CW-1:0] LO_C    = CW'(LO_THR);
  localparam logic [CW-1:0] HI_C    = CW'(HI_THR);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW:0]   FULL_C  = (CW+1)'(1 << CW);
  localparam logic [WW-1:0] SPAN_W  = WW'(SPAN);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   duty_q;
  logic          blank_q;
  logic [CW-1:0] above;
  logic [WW-1:0] wide;
  logic [CW:0]   scaled;
  logic [CW:0]   duty_cmd;
  logic [CW:0]   duty_eff;
  logic          wrap;

  assign above = speed_cmd - LO_C;
  assign wide  = WW'(above) << CW;

  // Scaling: a shift when the threshold span is a power of two.
  if ((SPAN & (SPAN - 1)) == 0) begin : g_shift
    assign scaled = (CW+1)'(wide >> SPAN_LOG);
  end else begin : g_div
    assign scaled = (CW+1)'(wide / SPAN_W);
  end

  always_comb begin
    if (speed_cmd <= LO_C)      duty_cmd = '0;
    else if (speed_cmd >= HI_C) duty_cmd = FULL_C;
    else                        duty_cmd = scaled;
    duty_eff = (duty_cmd > {1'b0, min_duty}) ? duty_cmd : {1'b0, min_duty};
  end

  assign wrap = run && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_MAX;
      duty_q  <= '0;
      blank_q <= 1'b0;
    end else if (!run) begin
      cnt_q   <= CNT_MAX;
      duty_q  <= '0;
      blank_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap) begin
        duty_q  <= duty_eff;
        blank_q <= 1'b0;
      end else if (ilim_trip) begin
        blank_q <= 1'b1;
      end
    end
  end

  assign hs_req = run && !blank_q && !ilim_trip && ({1'b0, cnt_q} < duty_q);
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DTW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           hs_req,
  input  logic [DTW-1:0] dead_cfg,
  output logic           hs_en,
  output logic           ls_en
);
  import pwm_floor_pkg::*;

  side_e          side_q;
  side_e          side_want;
  logic [DTW-1:0] gap_q;

  assign side_want = hs_req ? SIDE_HIGH : SIDE_LOW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      side_q <= SIDE_LOW;
      gap_q  <= '0;
      hs_en  <= 1'b0;
      ls_en  <= 1'b0;
    end else if (!run) begin
      side_q <= SIDE_LOW;
      gap_q  <= dead_cfg;
      hs_en  <= 1'b0;
      ls_en  <= 1'b0;
    end else if (side_want != side_q) begin
      side_q <= side_want;
      gap_q  <= dead_cfg;
      hs_en  <= 1'b0;
      ls_en  <= 1'b0;
    end else if (gap_q != '0) begin
      gap_q  <= gap_q - DTW'(1);
      hs_en  <= 1'b0;
      ls_en  <= 1'b0;
    end else begin
      hs_en  <= (side_q == SIDE_HIGH);
      ls_en  <= (side_q == SIDE_LOW);
    end
  end
endmodule

// File: rtl/pwm_bias.sv
module pwm_bias #(
  parameter int CW      = 8,
  parameter int CUT_THR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] speed_cmd,
  input  logic [CW-1:0] min_duty,
  output logic          bias_en
);
  localparam logic [CW-1:0] CUT_C = CW'(CUT_THR);

  logic cut_off;
  assign cut_off = (min_duty == '0) && (speed_cmd < CUT_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bias_en <= 1'b0;
    else        bias_en <= run && !cut_off;
  end
endmodule

// File: rtl/pwm_floor_gen.sv
module pwm_floor_gen #(
  parameter int CW      = 8,
  parameter int DTW     = 4,
  parameter int LO_THR  = 32,
  parameter int HI_THR  = 160,
  parameter int CUT_THR = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_en,
  input  logic [CW-1:0]  speed_cmd,
  input  logic [CW-1:0]  min_duty,
  input  logic           ilim_trip,
  input  logic [DTW-1:0] dead_cfg,
  output logic           hs_en,
  output logic           ls_en,
  output logic           bias_en
);
  logic hs_req;

  pwm_carrier #(.CW(CW), .LO_THR(LO_THR), .HI_THR(HI_THR)) carrier_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_en),
    .speed_cmd (speed_cmd),
    .min_duty  (min_duty),
    .ilim_trip (ilim_trip),
    .hs_req    (hs_req)
  );

  pwm_deadband #(.DTW(DTW)) deadband_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_en),
    .hs_req   (hs_req),
    .dead_cfg (dead_cfg),
    .hs_en    (hs_en),
    .ls_en    (ls_en)
  );

  pwm_bias #(.CW(CW), .CUT_THR(CUT_THR)) bias_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_en),
    .speed_cmd (speed_cmd),
    .min_duty  (min_duty),
    .bias_en   (bias_en)
  );
endmodule

// File: rtl/pwm_floor_gen_chk.sv
module pwm_floor_gen_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_en,
  input logic [CW-1:0] min_duty,
  input logic          ilim_trip,
  input logic          hs_en,
  input logic          ls_en,
  input logic          bias_en
);
  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  // R11
  stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!hs_en && !ls_en && !bias_en));

  // R11
  hs_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> $past(run_en));

  // R7
  ilim_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && ilim_trip) |=> !hs_en);

  // R8
  no_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> !$past(ls_en));

  // R10
  bias_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && (min_duty != '0)) |=> bias_en);
endmodule

bind pwm_floor_gen pwm_floor_gen_chk #(.CW(CW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_en    (run_en),
  .min_duty  (min_duty),
  .ilim_trip (ilim_trip),
  .hs_en     (hs_en),
  .ls_en     (ls_en),
  .bias_en   (bias_en)
);

// File: tb/pwm_floor_gen_tb_top.sv
module pwm_floor_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic [7:0] speed_cmd = 8'd0;
  logic [7:0] min_duty = 8'd0;
  logic       ilim_trip = 1'b0;
  logic [3:0] dead_cfg = 4'd2;
  logic       hs_en, ls_en, bias_en;

  int    n_tests = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // reference model state
  int m_cnt, m_duty, m_blank, m_side, m_gap, m_hs, m_ls, m_bias;

  always #4 clk = ~clk;

  pwm_floor_gen dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .speed_cmd(speed_cmd),
    .min_duty(min_duty), .ilim_trip(ilim_trip), .dead_cfg(dead_cfg),
    .hs_en(hs_en), .ls_en(ls_en), .bias_en(bias_en)
  );

  function automatic int duty_of(int c, int m);
    int s;
    if (c <= 32)       s = 0;
    else if (c >= 160) s = 256;
    else               s = ((c - 32) * 256) / 128;
    return (s > m) ? s : m;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 255; m_duty = 0; m_blank = 0; m_side = 0; m_gap = 0;
      m_hs = 0; m_ls = 0; m_bias = 0;
    end else begin
      int req;
      req = (run_en && !m_blank && !ilim_trip && (m_cnt < m_duty)) ? 1 : 0;
      if (!run_en) begin
        m_cnt = 255; m_duty = 0; m_blank = 0; m_side = 0;
        m_gap = dead_cfg; m_hs = 0; m_ls = 0;
      end else begin
        if (m_side != req) begin
          m_side = req; m_gap = dead_cfg; m_hs = 0; m_ls = 0;
        end else if (m_gap != 0) begin
          m_gap = m_gap - 1; m_hs = 0; m_ls = 0;
        end else begin
          m_hs = m_side; m_ls = 1 - m_side;
        end
        if (m_cnt == 255) begin
          m_duty = duty_of(speed_cmd, min_duty);
          m_blank = 0;
        end else if (ilim_trip) begin
          m_blank = 1;
        end
        m_cnt = (m_cnt + 1) % 256;
      end
      m_bias = (run_en && !(min_duty == 0 && speed_cmd < 16)) ? 1 : 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " hs_en model"}, int'(hs_en), m_hs);
      chk({cur_req, " ls_en model"}, int'(ls_en), m_ls);
      chk({cur_req, " bias_en model"}, int'(bias_en), m_bias);
      chk("R9 overlap", int'(hs_en && ls_en), 0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(string tag, int exp_hs, int exp_ls);
    int hs_c = 0;
    int ls_c = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      hs_c += int'(hs_en);
      ls_c += int'(ls_en);
    end
    chk({tag, " hs cycles"}, hs_c, exp_hs);
    chk({tag, " ls cycles"}, ls_c, exp_ls);
  endtask

  task automatic restart();
    run_en = 1'b0;
    cyc(3);
    run_en = 1'b1;
  endtask

  initial begin
    cyc(3);
    chk("R1 hs reset", int'(hs_en), 0);
    chk("R1 ls reset", int'(ls_en), 0);
    chk("R1 bias reset", int'(bias_en), 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 hs after reset", int'(hs_en), 0);
    chk("R1 bias after reset", int'(bias_en), 0);

    // R2 mid-range: D = 128, dead 2
    cur_req = "R2"; speed_cmd = 8'd96; dead_cfg = 4'd2; run_en = 1'b1;
    cyc(520);
    measure("R2 cmd96 d2", 125, 125);
    // R8 zero dead time
    cur_req = "R8"; dead_cfg = 4'd0;
    cyc(520);
    measure("R8 cmd96 d0", 127, 127);
    dead_cfg = 4'd2;
    // R2 full duty
    cur_req = "R2"; speed_cmd = 8'd200;
    cyc(520);
    measure("R2 cmd200 full", 256, 0);
    // R4 zero duty, no floor
    cur_req = "R4"; speed_cmd = 8'd32; min_duty = 8'd0;
    cyc(520);
    measure("R4 cmd32 zero", 0, 256);
    // R3 floor dominates
    cur_req = "R3"; speed_cmd = 8'd40; min_duty = 8'd100;
    cyc(520);
    measure("R3 floor100", 97, 153);
    // R3 command above floor: D = 216
    speed_cmd = 8'd140;
    cyc(520);
    measure("R3 cmd140 over floor", 213, 37);
    // R6 synchronous rectification, D = 64
    cur_req = "R6"; speed_cmd = 8'd64; min_duty = 8'd0;
    cyc(520);
    measure("R6 cmd64", 61, 189);

    // R5: change mid-period
    cur_req = "R5"; speed_cmd = 8'd96;
    restart();
    cyc(150);
    speed_cmd = 8'd200;
    cyc(60);
    chk("R5 old duty kept hs", int'(hs_en), 0);
    chk("R5 old duty kept ls", int'(ls_en), 1);
    cyc(256);
    chk("R5 new duty next period", int'(hs_en), 1);

    // R7: current limit blanks until wrap
    cur_req = "R7"; speed_cmd = 8'd96;
    restart();
    cyc(50);
    chk("R7 hs before trip", int'(hs_en), 1);
    ilim_trip = 1'b1;
    cyc(1);
    ilim_trip = 1'b0;
    chk("R7 hs cut", int'(hs_en), 0);
    cyc(49);
    chk("R7 still blanked hs", int'(hs_en), 0);
    chk("R7 low side on", int'(ls_en), 1);
    cyc(256);
    chk("R7 released after wrap", int'(hs_en), 1);

    // R10 sensor bias
    cur_req = "R10"; min_duty = 8'd0; speed_cmd = 8'd10;
    cyc(2);
    chk("R10 bias cut", int'(bias_en), 0);
    speed_cmd = 8'd20;
    cyc(1);
    chk("R10 bias above cut", int'(bias_en), 1);
    speed_cmd = 8'd10; min_duty = 8'd5;
    cyc(1);
    chk("R10 bias kept by floor", int'(bias_en), 1);

    // R11 stop mode
    cur_req = "R11"; speed_cmd = 8'd200; min_duty = 8'd0;
    cyc(600);
    run_en = 1'b0;
    cyc(1);
    chk("R11 hs stop", int'(hs_en), 0);
    chk("R11 ls stop", int'(ls_en), 0);
    chk("R11 bias stop", int'(bias_en), 0);
    run_en = 1'b1; dead_cfg = 4'd3;
    cyc(5);
    chk("R11 gap after start hs", int'(hs_en), 0);
    chk("R11 gap after start ls", int'(ls_en), 0);
    cyc(10);
    chk("R11 running again", int'(hs_en), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule